// File: doc/BRIEF.md
# Mixed-Mode Port Pin Logic

This block holds the digital side of two microcontroller I/O ports. A narrow 5-bit port mixes output types. Its three low bits are open-drain and its two high bits are pulled up. The top bit can be handed to a PWM generator. A wide 8-bit port has weak pull-ups on every bit. Its low five bits double as analog converter channels, and its top three bits feed two external interrupt inputs and a timer count input.

Each bit keeps a data latch that the internal bus writes. A read returns either the stored latch or the pad level. The pad level passes through a two-flop synchronizer first. While the converter is on, the analog-capable bits stop driving. The channel selected for conversion also reads back as 0 on a pin read. In idle and power-down the pins keep showing their latched data and bus writes have no effect. The PWM pin is the exception: it is forced low in those modes.

Top module: `port_pin_mux`

## Requirements
- R1: After reset every latch of both ports holds 1, so both read-latch results are all ones and the synchronized pin values are all ones.
- R2: Bits 0 to 2 of the 5-bit port are open-drain. A latch 0 asserts drive-low. A latch 1 asserts nothing, so there is no drive-high and no pull-up.
- R3: Bits 3 and 4 of the 5-bit port are pull-up outputs. A latch 0 asserts drive-low only. A latch 1 asserts pull-up only. No pin ever asserts drive-low together with pull-up or drive-high.
- R4: When PWM is enabled and the device is running, bit 4 of the 5-bit port follows the PWM level. Level 1 asserts drive-high and level 0 asserts drive-low, and the latch has no effect. When PWM is disabled, bit 4 behaves as in R3.
- R5: In idle or power-down with PWM enabled, bit 4 asserts drive-low only. All other pins keep following their latches.
- R6: A bus write to either port while idle or power-down is high leaves that port's latch unchanged.
- R7: A latch read (read-pin low) returns the latch value. A pin read (read-pin high) returns the pad level delayed by two clocks. The select is 0 for the 5-bit port, with its data in bits 4:0 and zeros above, and 1 for the 8-bit port.
- R8: On the 8-bit port a latch 0 asserts drive-low and a latch 1 asserts pull-up.
- R9: While the converter is enabled, bits 0 to 4 of the 8-bit port assert neither drive-low nor pull-up. Bits 5 to 7 keep following their latches.
- R10: While the converter is enabled, a pin read of the 8-bit port returns 0 at the bit given by the channel select (0 to 4). Every other bit reads normally. A select of 5 or above masks nothing, and a latch read is never masked.
- R11: The outputs for interrupt 0, interrupt 1 and the timer count carry the synchronized pad levels of 8-bit port bits 5, 6 and 7, two clocks after the pad changes.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wdata | input | 8 | Internal bus write data |
| wr_a | input | 1 | Write strobe for the 5-bit port latch |
| wr_b | input | 1 | Write strobe for the 8-bit port latch |
| rd_pin | input | 1 | 1 = read pad level, 0 = read latch |
| rd_sel_b | input | 1 | 1 = read 8-bit port, 0 = read 5-bit port |
| rd_data | output | 8 | Read result |
| pa_pad | input | 5 | Pad levels of the 5-bit port |
| pb_pad | input | 8 | Pad levels of the 8-bit port |
| pwm_en | input | 1 | Hand bit 4 of the 5-bit port to PWM |
| pwm_lvl | input | 1 | PWM waveform level |
| idle | input | 1 | Idle mode active |
| pdown | input | 1 | Power-down mode active |
| adc_en | input | 1 | Converter enabled |
| adc_ch | input | 3 | Selected converter channel |
| pa_drive_low | output | 5 | Strong low drive, 5-bit port |
| pa_drive_high | output | 5 | Strong high drive, 5-bit port |
| pa_pullup | output | 5 | Weak pull-up enable, 5-bit port |
| pb_drive_low | output | 8 | Strong low drive, 8-bit port |
| pb_pullup | output | 8 | Weak pull-up enable, 8-bit port |
| int0_n | output | 1 | Synchronized interrupt 0 input |
| int1_n | output | 1 | Synchronized interrupt 1 input |
| t0_cnt | output | 1 | Synchronized timer count input |

## Verification
The bench writes mixed patterns to the 5-bit port. This exposes any design that gives the open-drain bits a pull-up or lets pull-up bits drive high. It also checks pin reads at both one and two clocks after a pad change, which catches a synchronizer that is one stage too short or too long. It moves the converter channel across 0, 2 and 6, and switches the converter on and off. This catches a mask placed on the wrong bit, a mask applied to latch reads, or a mask that stays on once the converter is disabled. Finally it writes to the ports in idle and power-down and runs PWM through both modes. A design that lets those writes land, or that leaves the PWM pin toggling or pulled up while asleep, shows the wrong latch or drive values.

// File: rtl/port_pin_mux.sv
module port_pin_mux #(
  parameter int A_W     = 5,
  parameter int B_W     = 8,
  parameter int OD_BITS = 3,
  parameter int N_ANA   = 5,
  parameter int CH_W    = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [B_W-1:0] bus_wdata,
  input  logic           wr_a,
  input  logic           wr_b,
  input  logic           rd_pin,
  input  logic           rd_sel_b,
  output logic [B_W-1:0] rd_data,
  input  logic [A_W-1:0] pa_pad,
  input  logic [B_W-1:0] pb_pad,
  input  logic           pwm_en,
  input  logic           pwm_lvl,
  input  logic           idle,
  input  logic           pdown,
  input  logic           adc_en,
  input  logic [CH_W-1:0] adc_ch,
  output logic [A_W-1:0] pa_drive_low,
  output logic [A_W-1:0] pa_drive_high,
  output logic [A_W-1:0] pa_pullup,
  output logic [B_W-1:0] pb_drive_low,
  output logic [B_W-1:0] pb_pullup,
  output logic           int0_n,
  output logic           int1_n,
  output logic           t0_cnt
);
  localparam int PWM_BIT = A_W - 1;

  logic [A_W-1:0] pa_lat, pa_s1, pa_s2;
  logic [B_W-1:0] pb_lat, pb_s1, pb_s2;
  logic [B_W-1:0] ana_bits, rd_block;
  logic           sleep;

  assign sleep = idle | pdown;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_lat <= '1;
      pa_s1  <= '1;
      pa_s2  <= '1;
      pb_lat <= '1;
      pb_s1  <= '1;
      pb_s2  <= '1;
    end else begin
      pa_s1 <= pa_pad;
      pa_s2 <= pa_s1;
      pb_s1 <= pb_pad;
      pb_s2 <= pb_s1;
      if (wr_a && !sleep) pa_lat <= bus_wdata[A_W-1:0];
      if (wr_b && !sleep) pb_lat <= bus_wdata;
    end
  end

  always_comb begin
    for (int i = 0; i < A_W; i++) begin
      pa_drive_low[i]  = ~pa_lat[i];
      pa_drive_high[i] = 1'b0;
      pa_pullup[i]     = (i >= OD_BITS) ? pa_lat[i] : 1'b0;
    end
    if (pwm_en) begin
      pa_pullup[PWM_BIT] = 1'b0;
      if (sleep) begin
        pa_drive_low[PWM_BIT]  = 1'b1;
        pa_drive_high[PWM_BIT] = 1'b0;
      end else begin
        pa_drive_low[PWM_BIT]  = ~pwm_lvl;
        pa_drive_high[PWM_BIT] = pwm_lvl;
      end
    end
  end

  always_comb begin
    ana_bits = '0;
    rd_block = '0;
    if (adc_en) begin
      ana_bits[N_ANA-1:0] = '1;
      if (int'(adc_ch) < N_ANA) rd_block[adc_ch] = 1'b1;
    end
  end

  assign pb_drive_low = ~pb_lat & ~ana_bits;
  assign pb_pullup    =  pb_lat & ~ana_bits;

  assign rd_data = rd_sel_b ? (rd_pin ? (pb_s2 & ~rd_block) : pb_lat)
                            : {{(B_W-A_W){1'b0}}, (rd_pin ? pa_s2 : pa_lat)};

  assign int0_n = pb_s2[N_ANA];
  assign int1_n = pb_s2[N_ANA+1];
  assign t0_cnt = pb_s2[N_ANA+2];
endmodule

// File: rtl/port_pin_mux_chk.sv
module port_pin_mux_chk #(
  parameter int A_W  = 5,
  parameter int B_W  = 8,
  parameter int CH_W = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_a,
  input logic           wr_b,
  input logic           rd_pin,
  input logic           rd_sel_b,
  input logic [B_W-1:0] rd_data,
  input logic           pwm_en,
  input logic           idle,
  input logic           pdown,
  input logic           adc_en,
  input logic [CH_W-1:0] adc_ch,
  input logic [A_W-1:0] pa_lat,
  input logic [B_W-1:0] pb_lat,
  input logic [A_W-1:0] pa_drive_low,
  input logic [A_W-1:0] pa_drive_high,
  input logic [A_W-1:0] pa_pullup,
  input logic [B_W-1:0] pb_drive_low,
  input logic [B_W-1:0] pb_pullup
);
  a_r2_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_drive_high[2:0] == 3'b000) && (pa_pullup[2:0] == 3'b000));

  a_r3_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    ((pa_drive_low & (pa_pullup | pa_drive_high)) == '0) && ((pb_drive_low & pb_pullup) == '0));

  a_r5_pwm_sleep_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && (idle || pdown)) |-> (pa_drive_low[A_W-1] && !pa_drive_high[A_W-1] && !pa_pullup[A_W-1]));

  a_r6_write_a_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && (idle || pdown)) |=> $stable(pa_lat));

  a_r6_write_b_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && (idle || pdown)) |=> $stable(pb_lat));

  a_r9_analog_float: assert property (@(posedge clk) disable iff (!rst_n)
    adc_en |-> ((pb_drive_low[4:0] == 5'b0) && (pb_pullup[4:0] == 5'b0)));

  a_r10_channel_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_en && rd_pin && rd_sel_b && (adc_ch < 3'd5)) |-> (rd_data[adc_ch] == 1'b0));
endmodule

bind port_pin_mux port_pin_mux_chk #(.A_W(A_W), .B_W(B_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .wr_b(wr_b), .rd_pin(rd_pin),
  .rd_sel_b(rd_sel_b), .rd_data(rd_data), .pwm_en(pwm_en), .idle(idle),
  .pdown(pdown), .adc_en(adc_en), .adc_ch(adc_ch), .pa_lat(pa_lat),
  .pb_lat(pb_lat), .pa_drive_low(pa_drive_low), .pa_drive_high(pa_drive_high),
  .pa_pullup(pa_pullup), .pb_drive_low(pb_drive_low), .pb_pullup(pb_pullup)
);

// File: tb/tb_port_pin_mux.sv
module tb_port_pin_mux;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       wr_a = 0, wr_b = 0, rd_pin = 0, rd_sel_b = 0;
  logic [7:0] rd_data;
  logic [4:0] pa_pad = '1;
  logic [7:0] pb_pad = '1;
  logic       pwm_en = 0, pwm_lvl = 0, idle = 0, pdown = 0, adc_en = 0;
  logic [2:0] adc_ch = '0;
  logic [4:0] pa_drive_low, pa_drive_high, pa_pullup;
  logic [7:0] pb_drive_low, pb_pullup;
  logic       int0_n, int1_n, t0_cnt;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_pin_mux dut (
    .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .wr_a(wr_a), .wr_b(wr_b),
    .rd_pin(rd_pin), .rd_sel_b(rd_sel_b), .rd_data(rd_data),
    .pa_pad(pa_pad), .pb_pad(pb_pad), .pwm_en(pwm_en), .pwm_lvl(pwm_lvl),
    .idle(idle), .pdown(pdown), .adc_en(adc_en), .adc_ch(adc_ch),
    .pa_drive_low(pa_drive_low), .pa_drive_high(pa_drive_high), .pa_pullup(pa_pullup),
    .pb_drive_low(pb_drive_low), .pb_pullup(pb_pullup),
    .int0_n(int0_n), .int1_n(int1_n), .t0_cnt(t0_cnt)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic write_port(input bit to_b, input logic [7:0] d);
    @(negedge clk);
    bus_wdata = d; wr_a = !to_b; wr_b = to_b;
    @(negedge clk);
    wr_a = 0; wr_b = 0;
  endtask

  task automatic read(input bit pin, input bit sel_b, output logic [7:0] d);
    rd_pin = pin; rd_sel_b = sel_b;
    #1 d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    read(0, 0, d); chk("R1 latch A", d, 8'h1F);
    read(0, 1, d); chk("R1 latch B", d, 8'hFF);
    read(1, 1, d); chk("R1 pin B", d, 8'hFF);
    chk("R3 reset pullup A", {3'b0, pa_pullup}, 8'h18);
    chk("R2 reset drive A", {3'b0, pa_drive_low | pa_drive_high}, 8'h00);
    chk("R8 reset pullup B", pb_pullup, 8'hFF);
  endtask

  task automatic t_outputs_a();
    write_port(0, 8'h00);
    chk("R2 all low", {3'b0, pa_drive_low}, 8'h1F);
    chk("R3 no pullup at 0", {3'b0, pa_pullup}, 8'h00);
    write_port(0, 8'h1A);
    chk("R2 R3 drive low 1A", {3'b0, pa_drive_low}, 8'h05);
    chk("R3 pullup 1A", {3'b0, pa_pullup}, 8'h18);
    chk("R2 no high", {3'b0, pa_drive_high}, 8'h00);
    write_port(0, 8'h07);
    chk("R2 od released", {3'b0, pa_drive_low}, 8'h18);
    chk("R2 od no pullup", {3'b0, pa_pullup}, 8'h00);
  endtask

  task automatic t_pwm();
    write_port(0, 8'h1F);
    @(negedge clk); pwm_en = 1; pwm_lvl = 1;
    #1 chk("R4 pwm high", {5'b0, pa_drive_high[4], pa_drive_low[4], pa_pullup[4]}, 8'h04);
    @(negedge clk); pwm_lvl = 0;
    #1 chk("R4 pwm low", {5'b0, pa_drive_high[4], pa_drive_low[4], pa_pullup[4]}, 8'h02);
    write_port(0, 8'h0F);
    chk("R4 latch ignored", {5'b0, pa_drive_high[4], pa_drive_low[4], pa_pullup[4]}, 8'h02);
    @(negedge clk); pwm_lvl = 1;
    #1 chk("R4 latch ignored hi", {5'b0, pa_drive_high[4], pa_drive_low[4], pa_pullup[4]}, 8'h04);
    @(negedge clk); pwm_en = 0;
    #1 chk("R4 back to latch", {5'b0, pa_drive_high[4], pa_drive_low[4], pa_pullup[4]}, 8'h02);
  endtask

  task automatic t_sleep();
    logic [7:0] d;
    write_port(0, 8'h0A);
    write_port(1, 8'hA5);
    @(negedge clk); pwm_en = 1; pwm_lvl = 1; idle = 1;
    #1 chk("R5 idle pwm low", {5'b0, pa_drive_high[4], pa_drive_low[4], pa_pullup[4]}, 8'h02);
    chk("R5 idle others", {4'b0, pa_drive_low[3:0]}, 8'h05);
    write_port(0, 8'h15);
    write_port(1, 8'h00);
    read(0, 0, d); chk("R6 idle write A", d, 8'h0A);
    read(0, 1, d); chk("R6 idle write B", d, 8'hA5);
    chk("R5 idle B holds", pb_pullup, 8'hA5);
    @(negedge clk); idle = 0; pdown = 1; pwm_lvl = 0;
    #1 chk("R5 pd pwm low", {5'b0, pa_drive_high[4], pa_drive_low[4], pa_pullup[4]}, 8'h02);
    write_port(0, 8'h1F);
    read(0, 0, d); chk("R6 pd write A", d, 8'h0A);
    @(negedge clk); pdown = 0; pwm_en = 0;
    write_port(0, 8'h11);
    read(0, 0, d); chk("R6 awake write A", d, 8'h11);
  endtask

  task automatic t_read_pin();
    logic [7:0] d;
    @(negedge clk); pa_pad = 5'h15;
    @(negedge clk); read(1, 0, d); chk("R7 one clock old", d, 8'h1F);
    @(negedge clk); read(1, 0, d); chk("R7 two clocks", d, 8'h15);
    read(0, 0, d); chk("R7 latch read", d, 8'h11);
    @(negedge clk); pa_pad = 5'h1F;
  endtask

  task automatic t_port_b();
    write_port(1, 8'h3C);
    chk("R8 drive low", pb_drive_low, 8'hC3);
    chk("R8 pullup", pb_pullup, 8'h3C);
  endtask

  task automatic t_adc();
    logic [7:0] d;
    write_port(1, 8'h5A);
    @(negedge clk); pb_pad = 8'hFF; adc_en = 1; adc_ch = 3'd2;
    @(negedge clk);
    @(negedge clk);
    chk("R9 drive low", pb_drive_low, 8'hA0);
    chk("R9 pullup", pb_pullup, 8'h40);
    read(1, 1, d); chk("R10 ch2", d, 8'hFB);
    read(0, 1, d); chk("R10 latch unmasked", d, 8'h5A);
    @(negedge clk); adc_ch = 3'd0;
    read(1, 1, d); chk("R10 ch0", d, 8'hFE);
    @(negedge clk); adc_ch = 3'd6;
    read(1, 1, d); chk("R10 ch6 none", d, 8'hFF);
    @(negedge clk); adc_ch = 3'd2; adc_en = 0;
    read(1, 1, d); chk("R10 disabled", d, 8'hFF);
    chk("R9 disabled drive", pb_drive_low, 8'hA5);
  endtask

  task automatic t_alt();
    @(negedge clk); pb_pad = 8'h1F;
    @(negedge clk);
    chk("R11 one clock old", {5'b0, t0_cnt, int1_n, int0_n}, 8'h07);
    @(negedge clk);
    chk("R11 all low", {5'b0, t0_cnt, int1_n, int0_n}, 8'h00);
    @(negedge clk); pb_pad = 8'h40;
    @(negedge clk); @(negedge clk);
    chk("R11 int1 only", {5'b0, t0_cnt, int1_n, int0_n}, 8'h02);
    @(negedge clk); pb_pad = 8'hA0;
    @(negedge clk); @(negedge clk);
    chk("R11 int0 t0", {5'b0, t0_cnt, int1_n, int0_n}, 8'h05);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_outputs_a();
    t_pwm();
    t_sleep();
    t_read_pin();
    t_port_b();
    t_adc();
    t_alt();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule